// File: doc/BRIEF.md
# Resolution-Configurable Temperature Conversion Sequencer

This block sequences one temperature conversion at a time and owns the single 8-bit configuration register that selects the conversion resolution. A start strobe launches a busy period whose length follows the selected resolution. When the period ends, the block takes a 16-bit code from a modelled converter port, clears the bits below the selected resolution, presents the left-aligned result and pulses a done flag for one cycle.

The configuration register splits the 2-bit resolution code across its top and bottom bits. The five bits between them are a fixed reserved pattern, and bit 6 mirrors an external supply-low flag. A soft reset returns the resolution to its default, abandons any conversion in flight without a done pulse, and holds the block busy for a recovery period. Starts and register writes are refused while the block is busy. All durations are given in tenths of a millisecond and scaled by a clocks-per-millisecond parameter.

Top module: `temp_conv_seq`

## Requirements
- R1: After the synchronous reset, `cfg_o` reads 0x3A (with `supply_low_i` low), `busy_o` and `done_o` are 0 and `result_o` is 0.
- R2: The resolution code is {`cfg_o`[7], `cfg_o`[0]}, decoded as 2'b00 = 14 bits, 2'b01 = 12 bits, 2'b10 = 13 bits and 2'b11 = 11 bits. A write sets bit 7 and bit 0 from `reg_wdata_i`[7] and `reg_wdata_i`[0], and the change shows on `cfg_o` one cycle after the write edge.
- R3: An accepted start raises `busy_o` for exactly N cycles, where N = T*CLK_PER_MS/10 and T is 108 for 14 bits, 62 for 13 bits, 38 for 12 bits and 24 for 11 bits. With the default CLK_PER_MS of 10, N is 108, 62, 38 or 24.
- R4: `done_o` is a one-cycle pulse in the first cycle after `busy_o` falls at the end of a conversion. In that same cycle `result_o` shows `adc_code_i` as sampled on the final busy edge, and it holds that value until the next completion.
- R5: Result bits below the selected resolution are zero: the mask is 0xFFFC for 14 bits, 0xFFF8 for 13 bits, 0xFFF0 for 12 bits and 0xFFE0 for 11 bits, so the two low bits are always 0.
- R6: `cfg_o`[5:1] always reads the fixed reserved pattern RSVD_VAL (default 5'b11101), and no write changes it.
- R7: `cfg_o`[6] equals `supply_low_i` delayed by one cycle (1 = supply low), and no write changes it.
- R8: A start while `busy_o` is high is ignored. It is not queued, does not lengthen the busy period and produces no extra done pulse.
- R9: `soft_rst_i` restores the resolution code to 2'b00, aborts any conversion without a done pulse, and holds `busy_o` high for exactly 150*CLK_PER_MS/10 cycles (150 by default). Starts during that period are ignored, and a start after it is accepted.
- R10: A register write while `busy_o` is high is ignored, and the conversion in flight keeps the resolution it started with.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Conversion start strobe |
| reg_wr_i | input | 1 | Configuration register write enable |
| reg_wdata_i | input | 8 | Configuration write data |
| soft_rst_i | input | 1 | Soft reset command strobe |
| supply_low_i | input | 1 | Supply-low status flag |
| adc_code_i | input | 16 | Modelled converter output code |
| busy_o | output | 1 | Conversion or recovery in progress |
| done_o | output | 1 | One-cycle conversion-complete pulse |
| result_o | output | 16 | Masked, left-aligned conversion result |
| cfg_o | output | 8 | Configuration register read value |

## Verification
A start sampled on edge k raises `busy_o` in the cycle after k. It stays high for N cycles, and `done_o` with the new `result_o` appears in the first low cycle after that. A register write or a supply change is visible on `cfg_o` one cycle after its edge, and a soft reset shows as busy in the following cycle. The bench drives on falling edges and samples on falling edges. Its monitor measures the length of each busy run at those points and, on each done pulse, compares both the run length and the result against the item the driver queued. Recovery length and refused starts are counted cycle by cycle on the same sampling points.

// File: rtl/tcs_pkg.sv
package tcs_pkg;

  typedef enum logic [1:0] {
    RES14 = 2'b00,
    RES12 = 2'b01,
    RES13 = 2'b10,
    RES11 = 2'b11
  } res_code_e;

  typedef enum logic {
    RUN_CONV  = 1'b0,
    RUN_RECOV = 1'b1
  } run_kind_e;

  // Durations in tenths of a millisecond
  localparam int unsigned T14_TENTHS   = 108;
  localparam int unsigned T13_TENTHS   = 62;
  localparam int unsigned T12_TENTHS   = 38;
  localparam int unsigned T11_TENTHS   = 24;
  localparam int unsigned RECOV_TENTHS = 150;

  function automatic int unsigned tenths_to_cycles(int unsigned tenths,
                                                   int unsigned clk_per_ms);
    int unsigned c;
    c = (tenths * clk_per_ms) / 10;
    return (c == 0) ? 1 : c;
  endfunction

endpackage

// File: rtl/tcs_cfg_reg.sv
module tcs_cfg_reg
  import tcs_pkg::*;
#(
  parameter logic [4:0] RSVD_VAL = 5'b11101
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       soft_rst,
  input  logic       wr_en,
  input  logic [7:0] wdata,
  input  logic       supply_low,
  output res_code_e  res,
  output logic [7:0] cfg
);

  res_code_e res_q;
  logic      supply_q;
  logic      wdata_unused;

  // Only bit 7 and bit 0 are writable
  assign wdata_unused = &{1'b0, wdata[6:1]};

  always_ff @(posedge clk) begin
    if (rst || soft_rst) begin
      res_q <= RES14;
    end else if (wr_en) begin
      res_q <= res_code_e'({wdata[7], wdata[0]});
    end
  end

  always_ff @(posedge clk) begin
    if (rst) supply_q <= 1'b0;
    else     supply_q <= supply_low;
  end

  assign res = res_q;
  assign cfg = {res_q[1], supply_q, RSVD_VAL, res_q[0]};

endmodule

// File: rtl/tcs_busy_timer.sv
module tcs_busy_timer #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             busy,
  output logic             expire
);

  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (load) begin
      busy_q <= 1'b1;
      cnt_q  <= load_val;
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end
  end

  assign busy   = busy_q;
  assign expire = busy_q && (cnt_q == '0);

endmodule

// File: rtl/tcs_result_mask.sv
module tcs_result_mask
  import tcs_pkg::*;
#(
  parameter int W = 16
) (
  input  res_code_e      res,
  input  logic [W-1:0]   data,
  output logic [W-1:0]   masked
);

  for (genvar g = 0; g < W; g++) begin : g_bit
    logic keep;
    assign keep = (res == RES14 && g >= W - 14) ||
                  (res == RES13 && g >= W - 13) ||
                  (res == RES12 && g >= W - 12) ||
                  (res == RES11 && g >= W - 11);
    assign masked[g] = data[g] & keep;
  end

endmodule

// File: rtl/temp_conv_seq.sv
module temp_conv_seq
  import tcs_pkg::*;
#(
  parameter int unsigned CLK_PER_MS = 10,
  parameter int          RESULT_W   = 16,
  parameter logic [4:0]  RSVD_VAL   = 5'b11101
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start_i,
  input  logic                reg_wr_i,
  input  logic [7:0]          reg_wdata_i,
  input  logic                soft_rst_i,
  input  logic                supply_low_i,
  input  logic [RESULT_W-1:0] adc_code_i,
  output logic                busy_o,
  output logic                done_o,
  output logic [RESULT_W-1:0] result_o,
  output logic [7:0]          cfg_o
);

  localparam int unsigned C14   = tenths_to_cycles(T14_TENTHS, CLK_PER_MS);
  localparam int unsigned C13   = tenths_to_cycles(T13_TENTHS, CLK_PER_MS);
  localparam int unsigned C12   = tenths_to_cycles(T12_TENTHS, CLK_PER_MS);
  localparam int unsigned C11   = tenths_to_cycles(T11_TENTHS, CLK_PER_MS);
  localparam int unsigned CREC  = tenths_to_cycles(RECOV_TENTHS, CLK_PER_MS);
  localparam int unsigned CMAX  = (CREC > C14) ? CREC : C14;
  localparam int unsigned CNT_W = $clog2(CMAX + 1);

  res_code_e             res_cur;
  res_code_e             res_run_q;
  run_kind_e             kind_q;
  logic                  busy;
  logic                  expire;
  logic                  accept_start;
  logic                  wr_ok;
  logic                  load;
  logic                  finish;
  logic [CNT_W-1:0]      conv_len;
  logic [CNT_W-1:0]      load_val;
  logic [RESULT_W-1:0]   masked;
  logic                  done_q;
  logic [RESULT_W-1:0]   result_q;

  assign accept_start = start_i && !busy && !soft_rst_i;
  assign wr_ok        = reg_wr_i && !busy && !soft_rst_i;
  assign load         = soft_rst_i || accept_start;

  always_comb begin
    unique case (res_cur)
      RES14:   conv_len = CNT_W'(C14 - 1);
      RES13:   conv_len = CNT_W'(C13 - 1);
      RES12:   conv_len = CNT_W'(C12 - 1);
      default: conv_len = CNT_W'(C11 - 1);
    endcase
  end

  assign load_val = soft_rst_i ? CNT_W'(CREC - 1) : conv_len;

  tcs_cfg_reg #(.RSVD_VAL(RSVD_VAL)) u_cfg (
    .clk        (clk),
    .rst        (rst),
    .soft_rst   (soft_rst_i),
    .wr_en      (wr_ok),
    .wdata      (reg_wdata_i),
    .supply_low (supply_low_i),
    .res        (res_cur),
    .cfg        (cfg_o)
  );

  tcs_busy_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (load),
    .load_val (load_val),
    .busy     (busy),
    .expire   (expire)
  );

  tcs_result_mask #(.W(RESULT_W)) u_mask (
    .res    (res_run_q),
    .data   (adc_code_i),
    .masked (masked)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      kind_q    <= RUN_CONV;
      res_run_q <= RES14;
    end else if (soft_rst_i) begin
      kind_q    <= RUN_RECOV;
    end else if (accept_start) begin
      kind_q    <= RUN_CONV;
      res_run_q <= res_cur;
    end
  end

  assign finish = expire && (kind_q == RUN_CONV) && !soft_rst_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      done_q   <= 1'b0;
      result_q <= '0;
    end else begin
      done_q <= finish;
      if (finish) result_q <= masked;
    end
  end

  assign busy_o   = busy;
  assign done_o   = done_q;
  assign result_o = result_q;

endmodule

// File: rtl/tcs_checker.sv
module tcs_checker #(
  parameter int         RESULT_W = 16,
  parameter logic [4:0] RSVD_VAL = 5'b11101
) (
  input logic                clk,
  input logic                rst,
  input logic                start_i,
  input logic                reg_wr_i,
  input logic                soft_rst_i,
  input logic                supply_low_i,
  input logic                busy_o,
  input logic                done_o,
  input logic [RESULT_W-1:0] result_o,
  input logic [7:0]          cfg_o
);

  // R4: completion follows a busy cycle
  assert_done_after_busy_R4: assert property (@(posedge clk) disable iff (rst)
    done_o |-> $past(busy_o));

  // R4: done is a single-cycle pulse
  assert_done_single_R4: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  // R5: two lowest result bits are zero at completion
  assert_low_bits_zero_R5: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (result_o[1:0] == 2'b00));

  // R6: reserved field keeps its fixed pattern
  assert_rsvd_fixed_R6: assert property (@(posedge clk) disable iff (rst)
    reg_wr_i |=> (cfg_o[5:1] == RSVD_VAL));

  // R7: status bit tracks the supply flag one cycle late
  assert_supply_follow_R7: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (cfg_o[6] == $past(supply_low_i)));

  // R9: soft reset gives busy, no done, default resolution
  assert_soft_reset_R9: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(soft_rst_i)) |->
      (busy_o && !done_o && !cfg_o[7] && !cfg_o[0]));

  // R8: a start while busy does not end the busy period early
  assert_start_ignored_R8: assert property (@(posedge clk) disable iff (rst)
    (busy_o && start_i && !soft_rst_i && $past(busy_o) && !$past(start_i)) |->
      !done_o);

  // R10: resolution bits hold while busy
  assert_write_blocked_R10: assert property (@(posedge clk) disable iff (rst)
    (busy_o && !soft_rst_i) |=> ($stable(cfg_o[7]) && $stable(cfg_o[0])));

endmodule

bind temp_conv_seq tcs_checker #(.RESULT_W(RESULT_W), .RSVD_VAL(RSVD_VAL)) u_tcs_chk (
  .clk          (clk),
  .rst          (rst),
  .start_i      (start_i),
  .reg_wr_i     (reg_wr_i),
  .soft_rst_i   (soft_rst_i),
  .supply_low_i (supply_low_i),
  .busy_o       (busy_o),
  .done_o       (done_o),
  .result_o     (result_o),
  .cfg_o        (cfg_o)
);

// File: tb/tb_temp_conv_seq.sv
`timescale 1ns/1ps
module tb_temp_conv_seq;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic        reg_wr_i = 1'b0;
  logic [7:0]  reg_wdata_i = 8'h00;
  logic        soft_rst_i = 1'b0;
  logic        supply_low_i = 1'b0;
  logic [15:0] adc_code_i = 16'h0000;
  logic        busy_o;
  logic        done_o;
  logic [15:0] result_o;
  logic [7:0]  cfg_o;

  always #2.5 clk = ~clk;

  temp_conv_seq dut (
    .clk          (clk),
    .rst          (rst),
    .start_i      (start_i),
    .reg_wr_i     (reg_wr_i),
    .reg_wdata_i  (reg_wdata_i),
    .soft_rst_i   (soft_rst_i),
    .supply_low_i (supply_low_i),
    .adc_code_i   (adc_code_i),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .result_o     (result_o),
    .cfg_o        (cfg_o)
  );

  typedef struct {
    logic [15:0] res;
    int          cyc;
    string       tag;
  } exp_t;

  exp_t q[$];
  int   checks = 0;
  int   errors = 0;
  int   dones  = 0;
  int   run    = 0;
  bit   finished = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  // Expected values from the requirements (R2, R3, R5)
  function automatic int bits_of(input logic [1:0] code);
    case (code)
      2'b00: return 14;
      2'b01: return 12;
      2'b10: return 13;
      default: return 11;
    endcase
  endfunction

  function automatic int cyc_of(input logic [1:0] code);
    case (code)
      2'b00: return 108;
      2'b01: return 38;
      2'b10: return 62;
      default: return 24;
    endcase
  endfunction

  function automatic logic [15:0] exp_res(input logic [1:0] code, input logic [15:0] a);
    logic [15:0] m;
    m = 16'hFFFF << (16 - bits_of(code));
    return a & m;
  endfunction

  // Monitor: measures busy runs and scores each completion
  always @(negedge clk) begin
    if (!rst) begin
      if (busy_o) begin
        run++;
      end else begin
        if (done_o) begin
          dones++;
          if (q.size() == 0) begin
            check(0, "R8", "unexpected done", 1, 0);
          end else begin
            exp_t e;
            e = q.pop_front();
            check(result_o == e.res, "R4/R5", {e.tag, " result"}, result_o, e.res);
            check(run == e.cyc, "R3", {e.tag, " busy cycles"}, run, e.cyc);
          end
        end
        run = 0;
      end
    end
  end

  task automatic wr_cfg(input logic [7:0] v);
    @(negedge clk);
    reg_wr_i = 1'b1;
    reg_wdata_i = v;
    @(negedge clk);
    reg_wr_i = 1'b0;
  endtask

  task automatic wait_done(input int prev);
    int guard = 0;
    while (dones == prev && guard < 2000) begin
      @(negedge clk);
      guard++;
    end
  endtask

  task automatic conv(input logic [1:0] code, input logic [15:0] a, input string tag);
    exp_t e;
    int prev;
    e.res = exp_res(code, a);
    e.cyc = cyc_of(code);
    e.tag = tag;
    q.push_back(e);
    prev = dones;
    @(negedge clk);
    adc_code_i = a;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    wait_done(prev);
    @(negedge clk);
  endtask

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=0x1 expected=0x0");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int prev;
    int n;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(cfg_o == 8'h3A, "R1", "cfg after reset", cfg_o, 8'h3A);
    check(busy_o == 1'b0, "R1", "busy after reset", busy_o, 0);
    check(done_o == 1'b0, "R1", "done after reset", done_o, 0);
    check(result_o == 16'h0, "R1", "result after reset", result_o, 0);

    // R2 write resolution bits, R6 reserved pattern fixed
    wr_cfg(8'h81);
    check(cfg_o == 8'hBB, "R2", "write 0x81", cfg_o, 8'hBB);
    wr_cfg(8'h7E);
    check(cfg_o == 8'h3A, "R6", "write 0x7E", cfg_o, 8'h3A);
    wr_cfg(8'h01);
    check(cfg_o == 8'h3B, "R2", "write 0x01", cfg_o, 8'h3B);

    // R7 supply status
    @(negedge clk);
    supply_low_i = 1'b1;
    @(negedge clk);
    check(cfg_o[6] == 1'b1, "R7", "supply low bit", cfg_o[6], 1);
    wr_cfg(8'h00);
    check(cfg_o == 8'h7A, "R7", "write keeps status", cfg_o, 8'h7A);
    @(negedge clk);
    supply_low_i = 1'b0;
    @(negedge clk);
    check(cfg_o == 8'h3A, "R7", "supply ok", cfg_o, 8'h3A);

    // R3/R4/R5 each resolution
    conv(2'b00, 16'hFFFF, "R3 14b");
    wr_cfg(8'h80);
    conv(2'b10, 16'hFFFF, "R5 13b");
    wr_cfg(8'h01);
    conv(2'b01, 16'hA5A5, "R5 12b");
    wr_cfg(8'h81);
    conv(2'b11, 16'h5A5F, "R5 11b");
    check(result_o == 16'h5A40, "R4", "result held", result_o, 16'h5A40);

    // R8 start while busy ignored
    wr_cfg(8'h01);
    begin
      exp_t e;
      e.res = exp_res(2'b01, 16'h1234);
      e.cyc = cyc_of(2'b01);
      e.tag = "R8 restart";
      q.push_back(e);
    end
    prev = dones;
    @(negedge clk);
    adc_code_i = 16'h1234;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    repeat (5) @(negedge clk);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    wait_done(prev);
    repeat (100) @(negedge clk);
    check(dones == prev + 1, "R8", "single done", dones, prev + 1);
    check(busy_o == 1'b0, "R8", "no queued run", busy_o, 0);

    // R10 write while busy ignored
    wr_cfg(8'h00);
    begin
      exp_t e;
      e.res = exp_res(2'b00, 16'hBEEF);
      e.cyc = cyc_of(2'b00);
      e.tag = "R10 busy write";
      q.push_back(e);
    end
    prev = dones;
    @(negedge clk);
    adc_code_i = 16'hBEEF;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    repeat (3) @(negedge clk);
    reg_wr_i = 1'b1;
    reg_wdata_i = 8'h81;
    @(negedge clk);
    reg_wr_i = 1'b0;
    check(cfg_o == 8'h3A, "R10", "cfg during busy", cfg_o, 8'h3A);
    wait_done(prev);
    @(negedge clk);
    check(cfg_o == 8'h3A, "R10", "cfg after run", cfg_o, 8'h3A);

    // R9 soft reset aborts and recovers
    wr_cfg(8'h81);
    prev = dones;
    @(negedge clk);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    repeat (10) @(negedge clk);
    soft_rst_i = 1'b1;
    @(negedge clk);
    soft_rst_i = 1'b0;
    check(cfg_o == 8'h3A, "R9", "cfg after soft reset", cfg_o, 8'h3A);
    n = 0;
    while (busy_o && n < 1000) begin
      n++;
      start_i = (n == 20);
      @(negedge clk);
    end
    start_i = 1'b0;
    check(n == 150, "R9", "recovery cycles", n, 150);
    repeat (2) @(negedge clk);
    check(busy_o == 1'b0, "R9", "start in recovery ignored", busy_o, 0);
    check(dones == prev, "R9", "no done on abort", dones, prev);
    conv(2'b00, 16'h0F0F, "R9 after recovery");

    check(q.size() == 0, "R4", "scoreboard empty", q.size(), 0);
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule